// File: doc/BRIEF.md
# Serial Controller Interrupt Service Sequencer

This block services interrupts raised by an external dual-channel serial communications chip. The chip is reached through a single register port. The sequencer loads one access word into that port, then watches the port status until the access has finished. One access word combines a register select (command or data), a direction select (read or write), a channel select (A or B) and, for writes, an 8-bit payload.

A service pass starts on a wakeup request. The sequencer first runs an interrupt-acknowledge access, which returns a 3-bit vector from the chip. It then runs the clearing action that the vector selects, on the channel the vector names. After that it writes the return-from-interrupt command to channel A, unless the pass was marked as software-generated. In that case it skips the write and drops the mark. Every pass ends with a one-cycle done strobe that tells the requester to withdraw its wakeup.

Top module: `sio_isr_seq`

## Requirements
- R1: After reset, `busy`, `done`, `port_load` and `soft_pend` are all 0 and `port_word` is 0.
- R2: A `wake_req` seen while idle raises `busy` in the next cycle. In that same cycle it issues the acknowledge access: `port_load`=1 with `port_word`=16'h0B00 (bit 11 acknowledge qualifier, bit 9 write, bit 8 command register, bit 10 channel A clear, payload 0). The low 3 bits of the status that ends this access are taken as the vector.
- R3: After each `port_load` cycle, no further access is started until `port_status[15]` (chip select active) has been sampled as 0. A pass whose accesses each see L busy cycles therefore takes L+2 cycles per access.
- R4: Vectors 4 to 7 act on channel A (`port_word[10]`=1). Vectors 0 to 3 act on channel B (`port_word[10]`=0). Position within the group (vector mod 4) selects the action: 0 transmitter empty, 1 external status change, 2 receive available, 3 special receive.
- R5: Position 0 writes `CMD_RST_TX` (default 8'h28) to the channel's command register (bits 9 and 8 set). Position 1 writes `CMD_RST_EXT` (default 8'h10) in the same way.
- R6: Positions 2 and 3 perform exactly one read of the channel's data register (bits 11, 9 and 8 clear, payload 0).
- R7: With `soft_pend` clear, the vector action is followed by a write of `CMD_RET` (default 8'h38) to channel A's command register: word 16'h0700 | `CMD_RET`. A full pass is 3 accesses, and `done` rises 3·(L+2) cycles after the wake edge.
- R8: A `soft_mark` pulse sets `soft_pend`. A pass that finds it set skips the return write (2 accesses, `done` after 2·(L+2) cycles) and ends with `soft_pend` cleared.
- R9: `done` is high for exactly one cycle, and `busy` is 0 in the cycle after it.
- R10: `wake_req` pulses that arrive while `busy` is high are ignored. They start no extra access, and no new pass follows the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wake_req | input | 1 | Service request from the serial chip side |
| soft_mark | input | 1 | Marks the next pass as software-generated |
| port_status | input | 16 | Port status: bit 15 chip select active, bits 7:0 read data |
| port_load | output | 1 | One-cycle strobe loading `port_word` into the port |
| port_word | output | 16 | Access word: bit 11 ack, bit 10 channel A, bit 9 write, bit 8 command, bits 7:0 payload |
| busy | output | 1 | High from the cycle after wakeup through the done cycle |
| done | output | 1 | One-cycle end-of-pass strobe |
| soft_pend | output | 1 | Software-generated mark pending |

## Verification
Each access takes L+2 cycles, where L is the number of cycles the modelled chip holds chip select. The bench therefore expects `done` exactly 3·(L+2) cycles after the wake edge for a full pass, and 2·(L+2) for a marked pass. It counts edges from the wake edge and samples `done` and `busy` on the falling edge between clock edges, so each count is exact rather than "eventually". The logged access words are compared in order once `done` is seen. The idle state is checked one cycle after `done`, and `soft_pend` is checked one cycle after the mark pulse.

// File: rtl/sio_isr_seq.sv
module sio_isr_seq #(
  parameter logic [7:0] CMD_RST_TX  = 8'h28,
  parameter logic [7:0] CMD_RST_EXT = 8'h10,
  parameter logic [7:0] CMD_RET     = 8'h38
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wake_req,
  input  logic        soft_mark,
  input  logic [15:0] port_status,
  output logic        port_load,
  output logic [15:0] port_word,
  output logic        busy,
  output logic        done,
  output logic        soft_pend
);

  localparam logic [15:0] ACK_WORD = 16'h0B00;
  localparam logic [15:0] RET_WORD = {8'h07, CMD_RET};

  typedef enum logic [2:0] {
    S_IDLE, S_ACK, S_ACK_W, S_ACT, S_ACT_W, S_RET, S_RET_W, S_DONE
  } st_t;

  st_t        st;
  logic [2:0] vec;
  logic [15:0] act_word;

  wire cs_free = ~port_status[15];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      vec <= 3'd0;
    end else begin
      case (st)
        S_IDLE:  if (wake_req) st <= S_ACK;
        S_ACK:   st <= S_ACK_W;
        S_ACK_W: if (cs_free) begin
                   vec <= port_status[2:0];
                   st  <= S_ACT;
                 end
        S_ACT:   st <= S_ACT_W;
        S_ACT_W: if (cs_free) st <= soft_pend ? S_DONE : S_RET;
        S_RET:   st <= S_RET_W;
        S_RET_W: if (cs_free) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      soft_pend <= 1'b0;
    else if (soft_mark)
      soft_pend <= 1'b1;
    else if (st == S_ACT_W && cs_free)
      soft_pend <= 1'b0;
  end

  always_comb begin
    case (vec[1:0])
      2'd0:    act_word = {5'b0, vec[2], 2'b11, CMD_RST_TX};
      2'd1:    act_word = {5'b0, vec[2], 2'b11, CMD_RST_EXT};
      default: act_word = {5'b0, vec[2], 2'b00, 8'h00};
    endcase
  end

  always_comb begin
    case (st)
      S_ACK:   port_word = ACK_WORD;
      S_ACT:   port_word = act_word;
      S_RET:   port_word = RET_WORD;
      default: port_word = 16'h0000;
    endcase
  end

  assign port_load = (st == S_ACK) || (st == S_ACT) || (st == S_RET);
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);

endmodule

module sio_isr_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wake_req,
  input logic [15:0] port_status,
  input logic        port_load,
  input logic [15:0] port_word,
  input logic        busy,
  input logic        done
);

  p_load_in_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    port_load |-> busy);

  p_wake_acks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wake_req) |=> (busy && port_load && port_word == 16'h0B00));

  p_hold_while_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !port_load && port_status[15]) |=> !port_load);

  p_done_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));

  p_stay_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

endmodule

bind sio_isr_seq sio_isr_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .port_status(port_status),
  .port_load(port_load), .port_word(port_word), .busy(busy), .done(done)
);

// File: tb/sio_isr_seq_tb.sv
`timescale 1ns/1ps
module sio_isr_seq_tb_top;

  localparam logic [7:0] C_TX  = 8'h28;
  localparam logic [7:0] C_EXT = 8'h10;
  localparam logic [7:0] C_RET = 8'h38;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wake_req = 1'b0;
  logic        soft_mark = 1'b0;
  logic [15:0] port_status;
  logic        port_load, busy, done, soft_pend;
  logic [15:0] port_word;

  logic [3:0]  lat_cfg = 4'd0;
  logic [2:0]  vec_cfg = 3'd0;
  logic [3:0]  cnt;
  logic [7:0]  rdata;
  logic [15:0] log_w [0:63];
  int          nlog;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  sio_isr_seq #(.CMD_RST_TX(C_TX), .CMD_RST_EXT(C_EXT), .CMD_RET(C_RET)) dut_i (
    .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .soft_mark(soft_mark),
    .port_status(port_status), .port_load(port_load), .port_word(port_word),
    .busy(busy), .done(done), .soft_pend(soft_pend)
  );

  assign port_status = {cnt != 4'd0, 7'b0, rdata};

  always @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= 4'd0;
      rdata <= 8'h00;
      nlog  <= 0;
    end else if (port_load) begin
      cnt   <= lat_cfg;
      rdata <= port_word[11] ? {5'b0, vec_cfg} : 8'hA5;
      log_w[nlog[5:0]] <= port_word;
      nlog  <= nlog + 1;
    end else if (cnt != 4'd0) begin
      cnt <= cnt - 4'd1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] act_exp(input logic [2:0] v);
    case (v[1:0])
      2'd0:    return {5'b0, v[2], 2'b11, C_TX};
      2'd1:    return {5'b0, v[2], 2'b11, C_EXT};
      default: return {5'b0, v[2], 2'b00, 8'h00};
    endcase
  endfunction

  task automatic test_reset();
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 load", port_load, 0);
    chk("R1 word", port_word, 0);
    chk("R1 soft_pend", soft_pend, 0);
  endtask

  task automatic run_pass(input logic [2:0] v, input logic [3:0] lat,
                          input bit fake, input bit rewake);
    int base, cyc, exp_cyc, exp_n;
    @(negedge clk);
    vec_cfg = v;
    lat_cfg = lat;
    if (fake) begin
      soft_mark = 1'b1;
      @(negedge clk);
      soft_mark = 1'b0;
      @(negedge clk);
      chk("R8 mark sets soft_pend", soft_pend, 1);
    end
    base = nlog;
    wake_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wake_req = 1'b0;
    chk("R2 busy after wake", busy, 1);
    chk("R2 ack word", port_word, 16'h0B00);
    cyc = 0;
    while (!done && cyc < 500) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      wake_req = (rewake && cyc == 3);
    end
    wake_req = 1'b0;
    exp_n   = fake ? 2 : 3;
    exp_cyc = exp_n * (lat + 2);
    chk("R3 done cycle count", cyc, exp_cyc);
    chk(rewake ? "R10 access count" : "R7 access count", nlog - base, exp_n);
    chk("R2 logged ack", log_w[base[5:0]], 16'h0B00);
    chk(v[2] ? "R4 R5 R6 chan A action" : "R4 R5 R6 chan B action",
        log_w[(base + 1) & 63], act_exp(v));
    if (!fake) chk("R7 return word", log_w[(base + 2) & 63], {8'h07, C_RET});
    @(negedge clk);
    chk("R9 idle after done", {busy, done}, 2'b00);
    if (fake) chk("R8 soft_pend cleared", soft_pend, 0);
    if (rewake) begin
      @(negedge clk);
      @(negedge clk);
      chk("R10 no extra pass", nlog - base, 3);
      chk("R10 still idle", busy, 0);
    end
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    test_reset();
    @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    for (int i = 0; i < 8; i++) run_pass(i[2:0], i[3:0] % 4, 1'b0, 1'b0);
    run_pass(3'd5, 4'd2, 1'b1, 1'b0);
    run_pass(3'd2, 4'd0, 1'b1, 1'b0);
    run_pass(3'd6, 4'd9, 1'b0, 1'b0);
    run_pass(3'd1, 4'd4, 1'b0, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule